// File: doc/BRIEF.md
# Qualified Event Counter

This block is a single programmable performance-monitoring counter. A vector of event inputs arrives every cycle. It is arranged as a number of event groups of eight sub-events each, and every sub-event reports how many times it occurred in that cycle. A configuration word picks one group by its 8-bit code and a set of sub-events within it through an 8-bit mask. The selected per-cycle occurrences are summed.

The summed value is qualified before it reaches the 48-bit accumulator. A nonzero threshold turns it into a one-per-cycle condition, either "at least threshold" or, when inverted, "below threshold". An optional rising-edge detector counts the starts of that condition. A privilege filter allows counting only at level 0, only at levels 1 to 3, or at every level. Software can overwrite the accumulator at any time. When the accumulator wraps past all-ones, a sticky overflow flag is set, and an interrupt line follows that flag while interrupts are enabled.

Top module: `qual_evt_ctr`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the interrupt is 0, and the configuration is all zero, so counting is disabled.
- R2: The code field selects event group `code`, whose sub-event `s` occupies bits `(code*8+s)*OCC_W` and up of the event vector. Mask bit `s` includes sub-event `s`, and the per-cycle value is the sum of all included sub-events. A code at or above NUM_CODES gives a value of 0.
- R3: With threshold 0 and edge mode off, each permitted cycle adds the full per-cycle value.
- R4: With a nonzero threshold and invert off, a cycle adds 1 when the per-cycle value is greater than or equal to the threshold, and 0 otherwise.
- R5: With a nonzero threshold and invert on, a cycle adds 1 when the per-cycle value is below the threshold. With threshold 0, invert has no effect.
- R6: In edge mode a cycle adds 1 only when the qualified condition is true and was false in the previous cycle. With threshold 0 the condition is "per-cycle value nonzero".
- R7: The os bit allows counting at privilege 0. The usr bit allows counting at privileges 1, 2 and 3. With both bits clear, counting is allowed at every level. A disallowed cycle makes the condition false.
- R8: While the enable bit is clear nothing is added, and the edge history is held false. The first qualifying cycle after enabling therefore counts in edge mode.
- R9: A counter write loads the written value at the next edge and replaces any increment in that cycle.
- R10: An increment that carries out of 48 bits wraps the count and sets the sticky overflow flag. The clear input resets the flag unless a new overflow happens in the same cycle, in which case the flag stays set.
- R11: The interrupt output equals the overflow flag while the irq-enable bit is set, and is 0 otherwise.
- R12: The configuration word has this layout: code in bits [7:0], mask in [15:8], threshold in [23:16], invert in 24, edge in 25, os in 26, usr in 27, irq-enable in 28, enable in 29. A configuration write takes effect from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_occ_i | input | NUM_CODES*8*OCC_W | Per-cycle sub-event occurrence counts |
| priv_i | input | 2 | Current privilege level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 30 | Configuration word |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write value |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| cnt_o | output | CNT_W | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check several properties on every cycle: a counter write wins over any increment, the count holds while counting is disabled, a thresholded or edge-mode count never steps by more than one, the overflow flag is sticky, any drop in the count is accompanied by the overflow flag, and the interrupt never rises without an overflow. The bench's scenarios are needed to show that the right group and sub-events are summed and that the threshold, invert and edge decisions give the exact per-cycle increments. They also show the privilege filtering combinations, the edge history being cleared on disable, and the set-beats-clear race at wrap-around.

// File: rtl/qec_pkg.sv
package qec_pkg;
   localparam int CODE_W = 8;
   localparam int MASK_W = 8;
   localparam int THR_W  = 8;

   // Configuration word; first member is the most significant.
   typedef struct packed {
      logic              enable;
      logic              irq_en;
      logic              usr_en;
      logic              os_en;
      logic              edge_mode;
      logic              invert;
      logic [THR_W-1:0]  thresh;
      logic [MASK_W-1:0] umask;
      logic [CODE_W-1:0] code;
   } qec_cfg_t;

   localparam int CFG_W = $bits(qec_cfg_t);
endpackage

// File: rtl/qec_event_sum.sv
module qec_event_sum
   import qec_pkg::*;
#(
   parameter int NUM_CODES = 4,
   parameter int OCC_W     = 3,
   parameter int SUM_W     = 6
) (
   input  logic [NUM_CODES*MASK_W*OCC_W-1:0] evt_i,
   input  logic [CODE_W-1:0]                 code_i,
   input  logic [MASK_W-1:0]                 umask_i,
   output logic [SUM_W-1:0]                  sum_o
);
   localparam int GRP_W = MASK_W * OCC_W;

   logic [GRP_W-1:0] grp_sel;
   logic [OCC_W-1:0] picked [MASK_W];

   // Group mux: an unknown code leaves the group at zero.
   always_comb begin
      grp_sel = '0;
      for (int c = 0; c < NUM_CODES; c++) begin
         if (code_i == CODE_W'(c)) grp_sel = evt_i[c*GRP_W +: GRP_W];
      end
   end

   for (genvar s = 0; s < MASK_W; s++) begin : g_sub
      assign picked[s] = umask_i[s] ? grp_sel[s*OCC_W +: OCC_W] : '0;
   end

   always_comb begin
      sum_o = '0;
      for (int s = 0; s < MASK_W; s++) sum_o = sum_o + SUM_W'(picked[s]);
   end
endmodule

// File: rtl/qec_qualify.sv
module qec_qualify
   import qec_pkg::*;
#(
   parameter int SUM_W    = 6,
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SUM_W-1:0] sum_i,
   input  logic [THR_W-1:0] thresh_i,
   input  logic             invert_i,
   input  logic             edge_i,
   input  logic             os_en_i,
   input  logic             usr_en_i,
   input  logic             enable_i,
   input  logic [1:0]       priv_i,
   output logic [SUM_W-1:0] amount_o
);
   localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

   logic [CMP_W-1:0] sum_c, thr_c;
   logic             thr_zero, allowed, level_hit, cond, prev_q, edge_eff;

   assign sum_c    = CMP_W'(sum_i);
   assign thr_c    = CMP_W'(thresh_i);
   assign thr_zero = (thresh_i == '0);

   // Privilege filter: no bit set means every level counts.
   assign allowed = (!os_en_i && !usr_en_i) ||
                    ((priv_i == 2'd0) ? os_en_i : usr_en_i);

   always_comb begin
      if (thr_zero)      level_hit = (sum_c != '0);
      else if (invert_i) level_hit = (sum_c <  thr_c);
      else               level_hit = (sum_c >= thr_c);
   end

   assign cond = level_hit && allowed;

   if (HAS_EDGE) begin : g_edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        prev_q <= 1'b0;
         else if (!enable_i) prev_q <= 1'b0;
         else                prev_q <= cond;
      end
      assign edge_eff = edge_i;
   end else begin : g_no_edge
      assign prev_q   = 1'b0;
      assign edge_eff = 1'b0;
   end

   always_comb begin
      if (!enable_i)     amount_o = '0;
      else if (edge_eff) amount_o = SUM_W'(cond && !prev_q);
      else if (!thr_zero) amount_o = SUM_W'(cond);
      else               amount_o = allowed ? sum_i : '0;
   end
endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
   parameter int CNT_W = 48,
   parameter int AMT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             ovf_clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   logic [CNT_W-1:0] nxt;
   logic             carry;

   assign {carry, nxt} = {1'b0, cnt_o} + (CNT_W+1)'(amt_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
         ovf_o <= 1'b0;
      end else begin
         cnt_o <= wr_i ? wdata_i : nxt;
         if (!wr_i && carry) ovf_o <= 1'b1;
         else if (ovf_clr_i) ovf_o <= 1'b0;
      end
   end
endmodule

// File: rtl/qual_evt_ctr.sv
module qual_evt_ctr
   import qec_pkg::*;
#(
   parameter int NUM_CODES = 4,
   parameter int OCC_W     = 3,
   parameter int CNT_W     = 48,
   parameter bit HAS_EDGE  = 1'b1
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic [NUM_CODES*MASK_W*OCC_W-1:0] evt_occ_i,
   input  logic [1:0]                        priv_i,
   input  logic                              cfg_we_i,
   input  logic [CFG_W-1:0]                  cfg_wdata_i,
   input  logic                              cnt_we_i,
   input  logic [CNT_W-1:0]                  cnt_wdata_i,
   input  logic                              ovf_clr_i,
   output logic [CNT_W-1:0]                  cnt_o,
   output logic                              ovf_o,
   output logic                              irq_o
);
   localparam int MAX_SUM = MASK_W * ((1 << OCC_W) - 1);
   localparam int SUM_W   = $clog2(MAX_SUM + 1);

   if (CNT_W < 16 || CNT_W > 64) begin : g_bad_cnt_w
      $error("qual_evt_ctr: CNT_W must lie in 16..64");
   end
   if (NUM_CODES < 1 || NUM_CODES > (1 << CODE_W)) begin : g_bad_codes
      $error("qual_evt_ctr: NUM_CODES must lie in 1..256");
   end
   if (OCC_W < 1 || OCC_W > 8) begin : g_bad_occ_w
      $error("qual_evt_ctr: OCC_W must lie in 1..8");
   end

   qec_cfg_t         cfg_q;
   logic [SUM_W-1:0] sum_w, amt_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q <= '0;
      else if (cfg_we_i) cfg_q <= qec_cfg_t'(cfg_wdata_i);
   end

   qec_event_sum #(.NUM_CODES(NUM_CODES), .OCC_W(OCC_W), .SUM_W(SUM_W)) sum_i (
      .evt_i   (evt_occ_i),
      .code_i  (cfg_q.code),
      .umask_i (cfg_q.umask),
      .sum_o   (sum_w)
   );

   qec_qualify #(.SUM_W(SUM_W), .HAS_EDGE(HAS_EDGE)) qual_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sum_i    (sum_w),
      .thresh_i (cfg_q.thresh),
      .invert_i (cfg_q.invert),
      .edge_i   (cfg_q.edge_mode),
      .os_en_i  (cfg_q.os_en),
      .usr_en_i (cfg_q.usr_en),
      .enable_i (cfg_q.enable),
      .priv_i   (priv_i),
      .amount_o (amt_w)
   );

   qec_accum #(.CNT_W(CNT_W), .AMT_W(SUM_W)) acc_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (cnt_we_i),
      .wdata_i   (cnt_wdata_i),
      .amt_i     (amt_w),
      .ovf_clr_i (ovf_clr_i),
      .cnt_o     (cnt_o),
      .ovf_o     (ovf_o)
   );

   assign irq_o = ovf_o && cfg_q.irq_en;
endmodule

// File: rtl/qec_checker.sv
module qec_checker #(
   parameter int CNT_W = 48
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cnt_we_i,
   input logic [CNT_W-1:0] cnt_wdata_i,
   input logic             ovf_clr_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic             ovf_o,
   input logic             irq_o,
   input logic             enable_i,
   input logic             edge_i,
   input logic             thr_nz_i
);
   a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_we_i |=> cnt_o == $past(cnt_wdata_i));

   a_r8_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable_i && !cnt_we_i) |=> cnt_o == $past(cnt_o));

   // R4 and R6: thresholded or edge counting steps by at most one.
   a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && !cnt_we_i && (thr_nz_i || edge_i)) |=>
         (cnt_o - $past(cnt_o)) <= CNT_W'(1));

   a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && !ovf_clr_i) |=> ovf_o);

   a_r10_wrap_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_we_i |=> (cnt_o >= $past(cnt_o)) || ovf_o);

   a_r11_irq_needs_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ovf_o);
endmodule

bind qual_evt_ctr qec_checker #(.CNT_W(CNT_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cnt_we_i    (cnt_we_i),
   .cnt_wdata_i (cnt_wdata_i),
   .ovf_clr_i   (ovf_clr_i),
   .cnt_o       (cnt_o),
   .ovf_o       (ovf_o),
   .irq_o       (irq_o),
   .enable_i    (cfg_q.enable),
   .edge_i      (cfg_q.edge_mode),
   .thr_nz_i    (cfg_q.thresh != '0)
);

// File: tb/qual_evt_ctr_tb_top.sv
module qual_evt_ctr_tb_top;
   localparam int NUM_CODES = 4;
   localparam int OCC_W     = 3;
   localparam int CNT_W     = 48;
   localparam int EVT_W     = NUM_CODES * 8 * OCC_W;
   localparam int CLK_NS    = 20;
   localparam longint unsigned MOD = 64'd1 << CNT_W;

   logic             clk = 1'b0;
   logic             rst_ni = 1'b0;
   logic [EVT_W-1:0] evt = '0;
   logic [1:0]       priv = 2'd0;
   logic             cfg_we = 1'b0;
   logic [29:0]      cfg_wdata = '0;
   logic             cnt_we = 1'b0;
   logic [CNT_W-1:0] cnt_wdata = '0;
   logic             ovf_clr = 1'b0;
   logic [CNT_W-1:0] cnt;
   logic             ovf, irq;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    cmp_on = 1'b0;
   string cur_req = "R1";

   always #(CLK_NS/2) clk = ~clk;

   qual_evt_ctr #(.NUM_CODES(NUM_CODES), .OCC_W(OCC_W), .CNT_W(CNT_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .evt_occ_i(evt), .priv_i(priv),
      .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cnt_we_i(cnt_we),
      .cnt_wdata_i(cnt_wdata), .ovf_clr_i(ovf_clr),
      .cnt_o(cnt), .ovf_o(ovf), .irq_o(irq));

   // Behavioural reference model, advanced at each rising edge.
   longint unsigned m_cnt = 0;
   bit              m_ovf = 0;
   bit              m_prev = 0;
   bit [29:0]       m_cfg = '0;

   always @(posedge clk) begin
      int unsigned sum, thr, amt;
      bit ok, cond, wrapped;
      longint unsigned tmp;
      if (!rst_ni) begin
         m_cnt = 0; m_ovf = 0; m_prev = 0; m_cfg = '0;
      end else begin
         sum = 0;
         if (int'(m_cfg[7:0]) < NUM_CODES)
            for (int s = 0; s < 8; s++)
               if (m_cfg[8+s]) sum += evt[(int'(m_cfg[7:0])*8+s)*OCC_W +: OCC_W];
         thr = m_cfg[23:16];
         ok = (!m_cfg[26] && !m_cfg[27]) || (priv == 0 ? m_cfg[26] : m_cfg[27]);
         if (thr == 0) cond = (sum != 0);
         else if (m_cfg[24]) cond = (sum < thr);
         else cond = (sum >= thr);
         cond = cond && ok;
         if (!m_cfg[29]) amt = 0;
         else if (m_cfg[25]) amt = (cond && !m_prev) ? 1 : 0;
         else if (thr != 0) amt = cond ? 1 : 0;
         else amt = ok ? sum : 0;
         m_prev = m_cfg[29] ? cond : 1'b0;
         wrapped = 0;
         if (cnt_we) m_cnt = cnt_wdata;
         else begin
            tmp = m_cnt + amt;
            if (tmp >= MOD) begin tmp = tmp - MOD; wrapped = 1; end
            m_cnt = tmp;
         end
         if (wrapped) m_ovf = 1;
         else if (ovf_clr) m_ovf = 0;
         if (cfg_we) m_cfg = cfg_wdata;
      end
   end

   task automatic check(string req, longint unsigned act, longint unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, tagged with the scenario's requirement.
   always @(negedge clk) begin
      if (rst_ni && cmp_on) begin
         check({cur_req, " cnt"}, cnt, m_cnt);
         check({cur_req, " ovf"}, ovf, m_ovf);
         check({cur_req, " irq"}, irq, m_ovf && m_cfg[28]);
      end
   end

   function automatic logic [29:0] mk_cfg(int code, int mask, int thr, bit inv, bit edg,
                                          bit os, bit usr, bit ien, bit en);
      return {en, ien, usr, os, edg, inv, 8'(thr), 8'(mask), 8'(code)};
   endfunction

   task automatic cfg_write(logic [29:0] w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic cnt_write(logic [CNT_W-1:0] v);
      @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk); cnt_we = 1'b0;
   endtask

   task automatic run_rand(int n, int maxocc, bit rand_priv);
      repeat (n) begin
         @(negedge clk);
         if ($urandom_range(0, 2) == 0) evt = '0;
         else for (int i = 0; i < NUM_CODES*8; i++)
            evt[i*OCC_W +: OCC_W] = OCC_W'($urandom_range(0, maxocc));
         if (rand_priv) priv = 2'($urandom_range(0, 3));
      end
   endtask

   task automatic set_all(int v);
      @(negedge clk);
      for (int i = 0; i < NUM_CODES*8; i++) evt[i*OCC_W +: OCC_W] = OCC_W'(v);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset cnt", cnt, 0);
      check("R1 reset ovf", ovf, 0);
      check("R1 reset irq", irq, 0);
      rst_ni = 1'b1;
      cmp_on = 1'b1;

      cur_req = "R9";
      cnt_write(48'd1000);
      check("R9 loaded value", cnt, 1000);

      cur_req = "R2";
      cfg_write(mk_cfg(9, 8'hFF, 0, 0, 0, 0, 0, 0, 1));
      run_rand(10, 7, 0);
      @(negedge clk);
      check("R2 unknown code adds nothing", cnt, 1000);
      cfg_write(mk_cfg(1, 8'h0C, 0, 0, 0, 0, 0, 0, 1));
      run_rand(30, 7, 0);
      cfg_write(mk_cfg(3, 8'h81, 0, 0, 0, 0, 0, 0, 1));
      run_rand(20, 7, 0);

      cur_req = "R3";
      cfg_write(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 0, 1));
      run_rand(30, 7, 0);

      cur_req = "R4";
      cfg_write(mk_cfg(2, 8'hFF, 3, 0, 0, 0, 0, 0, 1));
      run_rand(30, 1, 0);
      cfg_write(mk_cfg(2, 8'hFF, 20, 0, 0, 0, 0, 0, 1));
      run_rand(30, 7, 0);

      cur_req = "R5";
      cfg_write(mk_cfg(1, 8'h03, 1, 1, 0, 0, 0, 0, 1));
      run_rand(30, 1, 0);
      cfg_write(mk_cfg(1, 8'hFF, 0, 1, 0, 0, 0, 0, 1));
      run_rand(20, 7, 0);

      cur_req = "R6";
      cfg_write(mk_cfg(2, 8'h10, 1, 0, 1, 0, 0, 0, 1));
      run_rand(40, 3, 0);
      cfg_write(mk_cfg(0, 8'hF0, 0, 0, 1, 0, 0, 0, 1));
      run_rand(30, 2, 0);

      cur_req = "R7";
      cfg_write(mk_cfg(0, 8'hFF, 0, 0, 0, 1, 0, 0, 1));
      run_rand(30, 7, 1);
      cfg_write(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 1, 0, 1));
      run_rand(30, 7, 1);
      cfg_write(mk_cfg(3, 8'hFF, 2, 0, 0, 0, 0, 0, 1));
      run_rand(30, 1, 1);
      priv = 2'd0;

      cur_req = "R8";
      set_all(5);
      cfg_write(mk_cfg(0, 8'hFF, 1, 0, 1, 0, 0, 0, 0));
      repeat (5) @(negedge clk);
      cnt_write(48'd77);
      repeat (5) @(negedge clk);
      check("R8 disabled count holds", cnt, 77);
      cfg_write(mk_cfg(0, 8'hFF, 1, 0, 1, 0, 0, 0, 1));
      repeat (5) @(negedge clk);
      check("R8 first edge after enable counted once", cnt, 78);
      run_rand(20, 3, 0);

      cur_req = "R12";
      cfg_write(mk_cfg(1, 8'h55, 0, 0, 0, 0, 0, 0, 1));
      cfg_write(mk_cfg(2, 8'hAA, 2, 0, 0, 0, 0, 0, 1));
      run_rand(10, 7, 0);

      cur_req = "R9";
      set_all(7);
      cfg_write(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 0, 1));
      cnt_write(48'h123456);
      check("R9 write beats increment", cnt, 48'h123456);

      cur_req = "R10";
      cnt_write(MOD - 64'd3);
      @(negedge clk);
      check("R10 overflow flag set on wrap", ovf, 1);
      check("R11 irq low while disabled", irq, 0);
      cur_req = "R11";
      cfg_write(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 1, 1));
      check("R11 irq follows overflow", irq, 1);
      cur_req = "R10";
      set_all(0);
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      check("R10 clear drops flag", ovf, 0);
      cnt_write(MOD - 64'd2);
      @(negedge clk); evt[OCC_W-1:0] = 3'd5; ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0; evt = '0;
      check("R10 set beats clear", ovf, 1);
      check("R10 wrapped value", cnt, 3);
      run_rand(10, 7, 0);

      @(negedge clk);
      cmp_on = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule